// File: doc/BRIEF.md
# Physical Register Lifetime Manager with Early Release

This block hands out physical registers to a rename stage and keeps the lifetime state of every physical register. Each cycle it takes a group of up to `REN_W` rename requests. A request flagged as having a dead destination gets no register. Every other request in the group gets the next identifier from a circular free list, or the whole group stalls. Writeback, operand-read and commit notifications then move each register through its lifetime: Free, then Empty, Used and Spent. Spent means the last reader is done but the register has not been released yet.

A single mode input selects the release policy. In conventional mode, a read marked as the last use only parks the register in Spent. The register goes back to the free list when the commit of its redefinition names it. In speculative mode, the same marked read returns the register to the free list at once, so Spent is never entered. In both modes a commit notification releases a register that no marked read has released. Released identifiers are appended at the tail of the free list, and allocation always takes from the head.

Top module: `preg_lifecycle_mgr`

## Requirements
- R1: After reset, physical registers 0 to NUM_LOG-1 are Used (state code 2) and all the others are Free (code 0). The free list holds NUM_LOG up to NUM_PHYS-1 in ascending order, head first.
- R2: The requests in a group that need a register receive identifiers in slot order (lowest slot first), taken consecutively from the head of the free list.
- R3: A register allocated in a cycle reads Empty (code 1) from the next cycle on.
- R4: A request with its dead-destination bit set gets `ren_got`=0 and consumes no free-list entry.
- R5: If the group needs more registers than the free list holds, `ren_stall` is 1, every `ren_got` bit is 0, and nothing is consumed.
- R6: A writeback moves an Empty register to Used in the next cycle.
- R7: In conventional mode (`spec_mode`=0), a read with its last-use bit set moves a Used register to Spent (code 3). The register is not added to the free list.
- R8: A commit notification makes the named register Free in the next cycle and appends it at the tail of the free list.
- R9: In speculative mode (`spec_mode`=1), a read with its last-use bit set makes the register Free in the next cycle and appends it to the free list.
- R10: A read without the last-use bit leaves the register state unchanged.
- R11: Registers released in one cycle are appended in this order: read ports in ascending index, then commit ports in ascending index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spec_mode | input | 1 | 1 = speculative release on a last-use read, 0 = conventional |
| ren_valid | input | REN_W | Rename slot carries an instruction with a destination |
| ren_dead | input | REN_W | Destination predicted never to be read |
| ren_stall | output | 1 | Group cannot be served this cycle |
| ren_got | output | REN_W | Slot received a physical register |
| ren_preg | output | REN_W*PW | Allocated identifier per slot (PW bits each, slot 0 lowest) |
| wb_valid | input | REN_W | Writeback notification per port |
| wb_preg | input | REN_W*PW | Register written back |
| rd_valid | input | REN_W | Operand-read notification per port |
| rd_last | input | REN_W | Read is predicted to be the last use |
| rd_preg | input | REN_W*PW | Register read |
| cm_valid | input | REN_W | Commit release per port |
| cm_preg | input | REN_W*PW | Register released by a committing redefinition |
| reg_state | output | NUM_PHYS*2 | Lifetime state per register (2 bits each, register 0 lowest) |

## Verification
A lost or duplicated free-list entry first shows up at the identifiers handed to rename. Because the list is strictly first-in first-out, such an error appears as a wrong `ren_preg` value once the head reaches that slot. The bench follows the expected list contents, so an error is caught at the first allocation that passes over it. A wrong lifetime transition shows in `reg_state` in the cycle after the triggering notification. The bench compares the whole state vector every cycle, so misordered priority between events or a wrong policy choice is caught one cycle after it happens.

// File: rtl/prm_pkg.sv
package prm_pkg;

    // Lifetime state of a physical register
    typedef enum logic [1:0] {
        PR_FREE  = 2'd0,
        PR_EMPTY = 2'd1,
        PR_USED  = 2'd2,
        PR_SPENT = 2'd3
    } preg_state_e;

endpackage

// File: rtl/prm_free_list.sv
module prm_free_list #(
    parameter int DEPTH     = 64,
    parameter int PW        = 6,
    parameter int NPOP      = 4,
    parameter int NPUSH     = 8,
    parameter int INIT_BASE = 32,
    parameter int INIT_CNT  = 32,
    parameter int CW        = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CW-1:0]              pop_cnt,
    input  logic [NPUSH-1:0]           push_valid,
    input  logic [NPUSH-1:0][PW-1:0]   push_id,
    output logic [NPOP-1:0][PW-1:0]    head_ids,
    output logic [CW-1:0]              avail
);

    logic [PW-1:0] mem [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] push_addr [NPUSH];
    logic [PW-1:0] npush;

    function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] a, input logic [PW-1:0] b);
        logic [PW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
        return s[PW-1:0];
    endfunction

    assign avail = cnt_q;

    always_comb begin
        for (int i = 0; i < NPOP; i++) head_ids[i] = mem[wrap_add(head_q, PW'(i))];
    end

    // Compact the released identifiers onto consecutive tail slots
    always_comb begin
        logic [PW-1:0] rank;
        rank = '0;
        for (int k = 0; k < NPUSH; k++) begin
            push_addr[k] = wrap_add(tail_q, rank);
            if (push_valid[k]) rank = rank + 1'b1;
        end
        npush = rank;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= PW'(INIT_CNT % DEPTH);
            cnt_q  <= CW'(INIT_CNT);
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i < INIT_CNT) ? PW'(INIT_BASE + i) : '0;
        end else begin
            for (int k = 0; k < NPUSH; k++)
                if (push_valid[k]) mem[push_addr[k]] <= push_id[k];
            head_q <= wrap_add(head_q, PW'(pop_cnt));
            tail_q <= wrap_add(tail_q, npush);
            cnt_q  <= cnt_q + CW'(npush) - pop_cnt;
        end
    end

    // R5
    fl_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop_cnt <= cnt_q);

    // R8
    fl_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/prm_state_table.sv
module prm_state_table
    import prm_pkg::*;
#(
    parameter int NUM_PHYS = 64,
    parameter int NUM_LOG  = 32,
    parameter int PW       = 6,
    parameter int NA       = 4,
    parameter int NF       = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NA-1:0]           alloc_valid,
    input  logic [NA-1:0][PW-1:0]   alloc_id,
    input  logic [NA-1:0]           wb_valid,
    input  logic [NA-1:0][PW-1:0]   wb_id,
    input  logic [NA-1:0]           spent_valid,
    input  logic [NA-1:0][PW-1:0]   spent_id,
    input  logic [NF-1:0]           free_valid,
    input  logic [NF-1:0][PW-1:0]   free_id,
    output preg_state_e             st_q [NUM_PHYS]
);

    preg_state_e st_d [NUM_PHYS];

    // Later loops win: release > spent > writeback > allocate
    always_comb begin
        for (int p = 0; p < NUM_PHYS; p++) begin
            st_d[p] = st_q[p];
            for (int a = 0; a < NA; a++)
                if (alloc_valid[a] && alloc_id[a] == PW'(p)) st_d[p] = PR_EMPTY;
            for (int a = 0; a < NA; a++)
                if (wb_valid[a] && wb_id[a] == PW'(p)) st_d[p] = PR_USED;
            for (int a = 0; a < NA; a++)
                if (spent_valid[a] && spent_id[a] == PW'(p)) st_d[p] = PR_SPENT;
            for (int f = 0; f < NF; f++)
                if (free_valid[f] && free_id[f] == PW'(p)) st_d[p] = PR_FREE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PHYS; p++)
                st_q[p] <= (p < NUM_LOG) ? PR_USED : PR_FREE;
        end else begin
            for (int p = 0; p < NUM_PHYS; p++) st_q[p] <= st_d[p];
        end
    end

    for (genvar a = 0; a < NA; a++) begin : g_wb_chk
        // R6
        wb_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
            wb_valid[a] |-> st_q[wb_id[a]] == PR_EMPTY);
    end

    for (genvar f = 0; f < NF; f++) begin : g_free_chk
        // R8
        free_of_free_chk: assert property (@(posedge clk) disable iff (rst)
            free_valid[f] |-> st_q[free_id[f]] != PR_FREE);
        for (genvar g = f + 1; g < NF; g++) begin : g_pair
            // R8
            dup_free_chk: assert property (@(posedge clk) disable iff (rst)
                !(free_valid[f] && free_valid[g] && free_id[f] == free_id[g]));
        end
    end

endmodule

// File: rtl/preg_lifecycle_mgr.sv
module preg_lifecycle_mgr
    import prm_pkg::*;
#(
    parameter int NUM_LOG  = 32,
    parameter int NUM_PHYS = 64,
    parameter int REN_W    = 4,
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int CW      = $clog2(NUM_PHYS + 1),
    localparam int RW      = $clog2(REN_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  spec_mode,
    input  logic [REN_W-1:0]      ren_valid,
    input  logic [REN_W-1:0]      ren_dead,
    output logic                  ren_stall,
    output logic [REN_W-1:0]      ren_got,
    output logic [REN_W*PW-1:0]   ren_preg,
    input  logic [REN_W-1:0]      wb_valid,
    input  logic [REN_W*PW-1:0]   wb_preg,
    input  logic [REN_W-1:0]      rd_valid,
    input  logic [REN_W-1:0]      rd_last,
    input  logic [REN_W*PW-1:0]   rd_preg,
    input  logic [REN_W-1:0]      cm_valid,
    input  logic [REN_W*PW-1:0]   cm_preg,
    output logic [NUM_PHYS*2-1:0] reg_state
);

    localparam int NF = 2 * REN_W;

    logic [REN_W-1:0][PW-1:0] wb_id, rd_id, cm_id, alloc_id, head_ids;
    logic [REN_W-1:0]         need;
    logic [RW-1:0]            slot_rank [REN_W];
    logic [RW-1:0]            need_tot;
    logic [CW-1:0]            avail, pop_cnt;
    logic [NF-1:0]            free_valid;
    logic [NF-1:0][PW-1:0]    free_id;
    logic [REN_W-1:0]         spent_valid;
    preg_state_e              st [NUM_PHYS];

    assign wb_id = wb_preg;
    assign rd_id = rd_preg;
    assign cm_id = cm_preg;

    // Rank each needy slot among the group
    always_comb begin
        logic [RW-1:0] rank;
        rank = '0;
        for (int i = 0; i < REN_W; i++) begin
            need[i]      = ren_valid[i] && !ren_dead[i];
            slot_rank[i] = rank;
            if (need[i]) rank = rank + 1'b1;
        end
        need_tot = rank;
    end

    assign ren_stall = CW'(need_tot) > avail;
    assign pop_cnt   = ren_stall ? '0 : CW'(need_tot);

    always_comb begin
        for (int i = 0; i < REN_W; i++) begin
            ren_got[i]  = need[i] && !ren_stall;
            alloc_id[i] = ren_got[i] ? head_ids[slot_rank[i]] : '0;
        end
    end
    assign ren_preg = alloc_id;

    // Release sources: marked reads (speculative mode) first, then commits
    always_comb begin
        for (int i = 0; i < REN_W; i++) begin
            free_valid[i]         = rd_valid[i] && rd_last[i] && spec_mode;
            free_id[i]            = rd_id[i];
            free_valid[REN_W + i] = cm_valid[i];
            free_id[REN_W + i]    = cm_id[i];
            spent_valid[i]        = rd_valid[i] && rd_last[i] && !spec_mode;
        end
    end

    prm_free_list #(
        .DEPTH(NUM_PHYS), .PW(PW), .NPOP(REN_W), .NPUSH(NF),
        .INIT_BASE(NUM_LOG), .INIT_CNT(NUM_PHYS - NUM_LOG), .CW(CW)
    ) u_free_list (
        .clk(clk), .rst(rst), .pop_cnt(pop_cnt),
        .push_valid(free_valid), .push_id(free_id),
        .head_ids(head_ids), .avail(avail)
    );

    prm_state_table #(
        .NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG), .PW(PW), .NA(REN_W), .NF(NF)
    ) u_state_table (
        .clk(clk), .rst(rst),
        .alloc_valid(ren_got), .alloc_id(alloc_id),
        .wb_valid(wb_valid), .wb_id(wb_id),
        .spent_valid(spent_valid), .spent_id(rd_id),
        .free_valid(free_valid), .free_id(free_id),
        .st_q(st)
    );

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_state_out
        assign reg_state[2*p +: 2] = st[p];
    end

    for (genvar i = 0; i < REN_W; i++) begin : g_chk
        // R2
        alloc_from_free_chk: assert property (@(posedge clk) disable iff (rst)
            ren_got[i] |-> st[alloc_id[i]] == PR_FREE);
        // R3
        alloc_empty_chk: assert property (@(posedge clk) disable iff (rst)
            ren_got[i] |=> st[$past(alloc_id[i])] == PR_EMPTY);
        // R9
        spec_release_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_valid[i] && rd_last[i] && spec_mode) |=> st[$past(rd_id[i])] == PR_FREE);
    end

endmodule

// File: tb/preg_lifecycle_mgr_bench.sv
module preg_lifecycle_mgr_bench;

    localparam int NL = 32;
    localparam int NP = 64;
    localparam int W  = 4;
    localparam int PW = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, spec_mode, ren_stall;
    logic [W-1:0] ren_valid, ren_dead, ren_got, wb_valid, rd_valid, rd_last, cm_valid;
    logic [W*PW-1:0] ren_preg, wb_preg, rd_preg, cm_preg;
    logic [NP*2-1:0] reg_state;

    preg_lifecycle_mgr #(.NUM_LOG(NL), .NUM_PHYS(NP), .REN_W(W)) u_preg_lifecycle_mgr (
        .clk(clk), .rst(rst), .spec_mode(spec_mode),
        .ren_valid(ren_valid), .ren_dead(ren_dead), .ren_stall(ren_stall),
        .ren_got(ren_got), .ren_preg(ren_preg),
        .wb_valid(wb_valid), .wb_preg(wb_preg),
        .rd_valid(rd_valid), .rd_last(rd_last), .rd_preg(rd_preg),
        .cm_valid(cm_valid), .cm_preg(cm_preg),
        .reg_state(reg_state)
    );

    int n_chk = 0, n_bad = 0;
    int mst [NP];
    int fl [NP];
    int fh, ft, fc;
    bit taken [NP];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dut_state(int p);
        return int'(reg_state[2*p +: 2]);
    endfunction

    function automatic int slot_id(int i);
        return int'(ren_preg[i*PW +: PW]);
    endfunction

    task automatic clear_in();
        ren_valid = '0; ren_dead = '0;
        wb_valid = '0; wb_preg = '0;
        rd_valid = '0; rd_last = '0; rd_preg = '0;
        cm_valid = '0; cm_preg = '0;
    endtask

    task automatic push_free(int id);
        fl[ft] = id; ft = (ft + 1) % NP; fc++;
    endtask

    task automatic cmp_states(string req);
        int mis;
        mis = 0;
        for (int p = 0; p < NP; p++)
            if (dut_state(p) != mst[p]) begin
                if (mis == 0) $display("  state mismatch preg %0d: %0d vs %0d", p, dut_state(p), mst[p]);
                mis++;
            end
        chk(req, mis, 0);
    endtask

    // One cycle: check rename outputs, advance the model, check states after the edge
    task automatic step();
        int need, k;
        bit stl;
        #1;
        need = 0;
        for (int i = 0; i < W; i++) if (ren_valid[i] && !ren_dead[i]) need++;
        stl = need > fc;
        chk("R5 stall", int'(ren_stall), int'(stl));
        k = 0;
        for (int i = 0; i < W; i++) begin
            if (ren_valid[i] && !ren_dead[i] && !stl) begin
                chk("R4 R5 got", int'(ren_got[i]), 1);
                chk("R2 R8 R11 id", slot_id(i), fl[(fh + k) % NP]);
                mst[fl[(fh + k) % NP]] = 1;
                k++;
            end else begin
                chk("R4 R5 got", int'(ren_got[i]), 0);
            end
        end
        fh = (fh + k) % NP; fc -= k;
        for (int i = 0; i < W; i++)
            if (wb_valid[i]) mst[wb_preg[i*PW +: PW]] = 2;
        for (int i = 0; i < W; i++)
            if (rd_valid[i] && rd_last[i]) begin
                if (spec_mode) begin
                    mst[rd_preg[i*PW +: PW]] = 0;
                    push_free(int'(rd_preg[i*PW +: PW]));
                end else begin
                    mst[rd_preg[i*PW +: PW]] = 3;
                end
            end
        for (int i = 0; i < W; i++)
            if (cm_valid[i]) begin
                mst[cm_preg[i*PW +: PW]] = 0;
                push_free(int'(cm_preg[i*PW +: PW]));
            end
        @(posedge clk);
        @(negedge clk);
        cmp_states("R3 R6 R7 R9 R10 state");
    endtask

    function automatic int pick(int s0, int s1);
        int st;
        st = int'($urandom % NP);
        for (int j = 0; j < NP; j++) begin
            int p;
            p = (st + j) % NP;
            if (!taken[p] && (mst[p] == s0 || mst[p] == s1)) return p;
        end
        return -1;
    endfunction

    task automatic rand_inputs();
        int p;
        clear_in();
        for (int p2 = 0; p2 < NP; p2++) taken[p2] = 1'b0;
        for (int i = 0; i < W; i++) begin
            ren_valid[i] = ($urandom % 2) == 1;
            ren_dead[i]  = ($urandom % 7) == 0;
        end
        for (int i = 0; i < W; i++)
            if ($urandom % 10 < 6) begin
                p = pick(1, 1);
                if (p >= 0) begin taken[p] = 1; wb_valid[i] = 1; wb_preg[i*PW +: PW] = PW'(p); end
            end
        for (int i = 0; i < W; i++)
            if ($urandom % 2 == 1) begin
                p = pick(2, 2);
                if (p >= 0) begin
                    taken[p] = 1; rd_valid[i] = 1; rd_preg[i*PW +: PW] = PW'(p);
                    rd_last[i] = ($urandom % 10) < 4;
                end
            end
        for (int i = 0; i < W; i++)
            if ($urandom % 10 < 3) begin
                p = pick(2, 3);
                if (p >= 0) begin taken[p] = 1; cm_valid[i] = 1; cm_preg[i*PW +: PW] = PW'(p); end
            end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; spec_mode = 1'b0;
        clear_in();
        for (int p = 0; p < NP; p++) mst[p] = (p < NL) ? 2 : 0;
        for (int i = 0; i < NP; i++) fl[i] = (i < NP - NL) ? NL + i : 0;
        fh = 0; ft = NP - NL; fc = NP - NL;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        cmp_states("R1 reset");
        chk("R1 no stall", int'(ren_stall), 0);

        // R2 R4: group with a dead destination in slot 1
        ren_valid = 4'hF; ren_dead = 4'b0010;
        #1;
        chk("R2 slot0 id", slot_id(0), 32);
        chk("R4 dead slot", int'(ren_got[1]), 0);
        chk("R2 slot2 id", slot_id(2), 33);
        chk("R2 slot3 id", slot_id(3), 34);
        step(); clear_in();
        chk("R3 empty", dut_state(32), 1);
        chk("R4 not consumed", dut_state(35), 0);

        // R6 writeback
        wb_valid[0] = 1; wb_preg[0 +: PW] = 6'd32;
        step(); clear_in();
        chk("R6 used", dut_state(32), 2);

        // R10 ordinary read
        rd_valid[1] = 1; rd_preg[PW +: PW] = 6'd32;
        step(); clear_in();
        chk("R10 unchanged", dut_state(32), 2);

        // R7 conventional last-use read
        rd_valid[0] = 1; rd_last[0] = 1; rd_preg[0 +: PW] = 6'd32;
        step(); clear_in();
        chk("R7 spent", dut_state(32), 3);

        // R8 commit release
        cm_valid[2] = 1; cm_preg[2*PW +: PW] = 6'd32;
        step(); clear_in();
        chk("R8 freed", dut_state(32), 0);

        // R9 R11 speculative release plus commit in one cycle
        spec_mode = 1'b1;
        wb_valid[0] = 1; wb_preg[0 +: PW] = 6'd33;
        wb_valid[1] = 1; wb_preg[PW +: PW] = 6'd34;
        step(); clear_in();
        rd_valid[3] = 1; rd_last[3] = 1; rd_preg[3*PW +: PW] = 6'd33;
        cm_valid[0] = 1; cm_preg[0 +: PW] = 6'd34;
        step(); clear_in();
        chk("R9 freed at once", dut_state(33), 0);

        // Drain the list up to the released entries
        for (int g = 0; g < 7; g++) begin
            ren_valid = 4'hF;
            step(); clear_in();
        end
        ren_valid = 4'hF;
        #1;
        chk("R2 tail wrap id", slot_id(0), 63);
        chk("R8 appended id", slot_id(1), 32);
        chk("R11 read first", slot_id(2), 33);
        chk("R11 commit next", slot_id(3), 34);
        step(); clear_in();

        // R5 empty list
        ren_valid = 4'b0001;
        #1;
        chk("R5 stall empty", int'(ren_stall), 1);
        chk("R5 no grant", int'(ren_got), 0);
        step(); clear_in();

        for (int c = 0; c < 3000; c++) begin
            if (c == 1500) spec_mode = 1'b0;
            rand_inputs();
            step();
        end
        clear_in();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule